// File: doc/BRIEF.md
# Fixed-Latency Bus Receive Release Unit

This unit sits on the receiving end of a bus whose transit time varies from message to message. The variation stays within a known range of THETA1 to THETA2 cycles. The transmitter and receiver run at the same frequency. The transmitter only launches on send slots, which are cycles whose count is congruent to RHO modulo W, where W = THETA2 − THETA1 + 1. Because of this rule, any cycle of arrival falls in exactly one window of W cycles, and that window points back to one send slot. The unit works out the send cycle from the arrival cycle and stamps the message with the worst-case arrival cycle, send cycle + THETA2. It then holds the message until that cycle.

The unit keeps its own cycle counter and a modulo-W phase counter. It computes the release stamp with an add and a subtract, so it needs no divider. Stamped messages wait in a small circular queue. The head leaves when the counter equals its stamp. A message whose arrival lands on its own release cycle bypasses the queue and leaves in that same cycle. The core therefore sees each message at the same cycle on every run, whatever the actual transit time was.

Top module: `det_release_unit`

## Requirements
- R1: While reset is held, `dom_cnt` is 0, `rel_valid` is 0 and `err` is 0.
- R2: `dom_cnt` advances by exactly one on every clock after reset and wraps modulo 2^32.
- R3: A message sent at slot cycle xT (xT mod W = RHO) and accepted with `rx_valid` in the cycle where `dom_cnt` = yR, with THETA1 ≤ yR − xT ≤ THETA2, drives `rel_valid` high in exactly the one cycle where `dom_cnt` = xT + THETA2. This equals floor((yR − THETA1 − RHO)/W)·W + RHO + THETA2.
- R4: `rel_data` in the release cycle equals the `rx_data` that came with the message.
- R5: Messages leave in the order they arrived, at most one per cycle. When a queued entry and a new arrival both carry the current stamp, the queued (older) one leaves.
- R6: A message that arrives exactly THETA2 cycles after its send slot, with an empty queue, is released in its arrival cycle.
- R7: `rel_valid` is high only in cycles where (`dom_cnt` − RHO − THETA2) mod W = 0.
- R8: An arrival that finds the queue holding DEPTH entries, with no departure in that cycle, sets `err`. `err` then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A message arrives this cycle |
| rx_data | input | DATA_W | Payload of the arriving message |
| rel_valid | output | 1 | A message is handed to the core this cycle |
| rel_data | output | DATA_W | Payload being handed over |
| dom_cnt | output | 32 | Free-running receiver cycle count |
| err | output | 1 | Sticky queue overflow flag |

## Verification
Two functions can fall in the same cycle: accepting an arrival and releasing a message. Under legal traffic they coincide only when a message arrives at its worst-case cycle, and then it must leave in that cycle by the bypass path. The sweep provokes this case by giving every delay from THETA1 to THETA2 to back-to-back slots, and the check there is that `rel_valid` rises in the arrival cycle itself. A directed burst of arrivals in consecutive cycles makes a queued head and a new arrival share a stamp. The check there is that the older payload is released and the new one waits.

// File: rtl/det_release_unit.sv
module det_release_unit #(
  parameter int DATA_W = 8,
  parameter int THETA1 = 2,
  parameter int THETA2 = 5,
  parameter int RHO    = 1,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rel_valid,
  output logic [DATA_W-1:0] rel_data,
  output logic [31:0]       dom_cnt,
  output logic              err
);
  localparam int W     = THETA2 - THETA1 + 1;
  localparam int PH_W  = $clog2(W + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CQ_W  = $clog2(DEPTH + 1);
  localparam int PH0   = (W - ((THETA1 + RHO) % W)) % W;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(W - 1);
  localparam logic [PH_W-1:0]  PH_INIT  = PH_W'(PH0);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CQ_W-1:0]  FULL     = CQ_W'(DEPTH);
  localparam logic [31:0]      SPAN     = 32'(THETA2 - THETA1);

  logic [PH_W-1:0]   phase;
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [31:0]       stamp_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CQ_W-1:0]   count;

  logic [31:0] in_stamp;
  logic        empty, head_hit, bypass, push, overflow;

  // phase = (dom_cnt - THETA1 - RHO) mod W, so stamp = yR - THETA1 - phase + THETA2
  assign in_stamp = dom_cnt + SPAN - 32'(phase);
  assign empty    = (count == '0);
  assign head_hit = !empty && (stamp_q[rd_ptr] == dom_cnt);
  assign bypass   = empty && rx_valid && (in_stamp == dom_cnt);
  assign push     = rx_valid && !bypass && ((count != FULL) || head_hit);
  assign overflow = rx_valid && !bypass && (count == FULL) && !head_hit;

  assign rel_valid = head_hit || bypass;
  assign rel_data  = head_hit ? data_q[rd_ptr] : rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dom_cnt <= '0;
      phase   <= PH_INIT;
    end else begin
      dom_cnt <= dom_cnt + 32'd1;
      phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      err    <= 1'b0;
    end else begin
      if (push)     wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (head_hit) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !head_hit)      count <= count + 1'b1;
      else if (!push && head_hit) count <= count - 1'b1;
      if (overflow) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      data_q[wr_ptr]  <= rx_data;
      stamp_q[wr_ptr] <= in_stamp;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dom_cnt == $past(dom_cnt) + 32'd1); // R2
  AST_REL_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> phase == PH_LAST); // R7
  AST_REL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (!empty || rx_valid)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
endmodule

// File: tb/tb_det_release_unit.sv
module tb_det_release_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TH1 = 2, TH2 = 5, RHO = 1, W = TH2 - TH1 + 1, DEPTH = 4;
  localparam int N = 80;

  logic        clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rel_valid, err;
  logic [7:0]  rel_data;
  logic [31:0] dom_cnt;

  int checks = 0, fails = 0;
  bit finished = 0;
  int xs [N];
  int ys [N];
  logic [7:0] ds [N];

  det_release_unit #(.DATA_W(8), .THETA1(TH1), .THETA2(TH2), .RHO(RHO), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rel_valid(rel_valid), .rel_data(rel_data), .dom_cnt(dom_cnt), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at dom_cnt %0d", req, act, exp, dom_cnt);
    end
  endtask

  task automatic do_reset();
    rx_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k, rp, sp;
    longint c0;
    k = 2;
    for (int i = 0; i < N; i++) begin
      if (i >= 16) k += 1 + $urandom_range(0, 1);
      else if (i > 0) k += 1;
      xs[i] = RHO + W * k;
      ys[i] = xs[i] + ((i < 16) ? (TH1 + i % W) : (TH1 + $urandom_range(0, W - 1)));
      ds[i] = 8'($urandom_range(0, 255));
    end

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(dom_cnt == 0, "R1 dom_cnt", dom_cnt, 0);
    chk(rel_valid == 1'b0, "R1 rel_valid", rel_valid, 0);
    chk(err == 1'b0, "R1 err", err, 0);
    rst_n = 1'b1;

    rp = 0; sp = 0;
    c0 = -1;
    while (rp < N) begin
      int c;
      bit exp_rel;
      @(negedge clk);
      c = int'(dom_cnt);
      if (c == 10) c0 = c;
      if (c0 >= 0 && c == 60) chk(dom_cnt == 32'(c0 + 50), "R2 count step", dom_cnt, c0 + 50);
      if (sp < N && ys[sp] == c) begin
        rx_valid = 1'b1; rx_data = ds[sp]; sp++;
      end else begin
        rx_valid = 1'b0;
      end
      #1;
      exp_rel = (xs[rp] + TH2 == c);
      if (rel_valid !== exp_rel || exp_rel) begin
        if (ys[rp] == xs[rp] + TH2)
          chk(rel_valid === exp_rel, "R6 same-cycle release", rel_valid, exp_rel);
        else
          chk(rel_valid === exp_rel, "R3 release cycle", rel_valid, exp_rel);
      end
      if (exp_rel && rel_valid === 1'b1) begin
        chk(rel_data == ds[rp], "R4 R5 payload", rel_data, ds[rp]);
        chk(((c - RHO - TH2) % W) == 0, "R7 slot phase", (c - RHO - TH2) % W, 0);
        rp++;
      end else if (exp_rel) begin
        rp++;
      end
    end
    @(negedge clk);
    chk(err == 1'b0, "R8 no error on legal traffic", err, 0);

    do_reset();
    forever begin
      int c;
      @(negedge clk);
      c = int'(dom_cnt);
      rx_valid = (c >= 3 && c <= 8);
      rx_data  = 8'(8'hA0 + c);
      #1;
      if (c == 6) begin
        chk(rel_valid == 1'b1, "R5 older entry leaves", rel_valid, 1);
        chk(rel_data == 8'hA3, "R5 older payload", rel_data, 8'hA3);
      end
      if (c == 7 || c == 8) chk(rel_valid == 1'b0, "R5 one release per stamp", rel_valid, 0);
      if (c == 8) chk(err == 1'b0, "R8 before overflow", err, 0);
      if (c == 9) chk(err == 1'b1, "R8 overflow flagged", err, 1);
      if (c == 20) begin
        chk(err == 1'b1, "R8 sticky", err, 1);
        break;
      end
    end
    do_reset();
    @(negedge clk);
    chk(err == 1'b0, "R8 cleared by reset", err, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule